// File: doc/BRIEF.md
# Fixed-point to integer rounding converter

This block turns a sign bit and an unsigned fixed-point magnitude into a rounded two's-complement integer, under one of four rounding modes. The default shape takes a 64-bit magnitude whose low 7 bits are fraction and whose top bit is always zero, and returns a 32-bit signed integer. Alongside the value it reports three status bits: the result could not be represented (invalid), fraction bits were dropped (inexact), and rounding made the magnitude larger than the exact input (rounded up).

All directed rounding is done with one addition. A constant is added below the binary point: half a unit for nearest-even, all fraction ones for rounding away from zero, zero otherwise. The result is the sum with the fraction removed. When a nearest-even tie occurs, the lowest integer bit is then cleared. An out-of-range result gives a fixed marker value (only the top bit set) and no other status. Parameters change the widths, for example to a 64-bit fraction word with a 64-bit result. A parameter also selects an unsigned variant, in which the sign is ignored, overflow gives all ones, and only round-up among the directed modes adds an increment.

Operands enter on a valid/ready stream and results leave on a second stream through one register stage. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. The result is offered on `out_valid` from that edge on. It stays unchanged until the consumer takes it with `out_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so full throughput is kept under continuous readiness.

Top module: `fxr_round_conv`

## Requirements
- R1: With `in_mode` = 2'b00 (nearest-even), the magnitude is rounded to the nearest integer. On an exact tie (fraction equal to binary 1000000) the result is the even neighbour.
- R2: With `in_mode` = 2'b11 (toward zero), the fraction bits are discarded.
- R3: With `in_mode` = 2'b01 (down) and a negative sign, or `in_mode` = 2'b10 (up) and a positive sign, any nonzero fraction increments the magnitude by one. The opposite pairings discard the fraction.
- R4: When `in_sign` is 1, the rounded magnitude is returned negated in two's complement. A positive operand never yields a negative valid result.
- R5: `out_invalid` is set when a positive rounded magnitude is at least 2^31, or a negative one exceeds 2^31. The output is then 32'h8000_0000, with `out_inexact` and `out_rounded_up` both 0.
- R6: For a valid result, `out_inexact` is 1 exactly when any of the 7 fraction bits is nonzero.
- R7: For a valid result, `out_rounded_up` is 1 exactly when the rounded magnitude is greater than the integer part of the input. It is never set without `out_inexact`.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R9: While `rst_n` is low, `out_valid` is 0.
- R10: An operand accepted on an edge appears on the outputs, with `out_valid` high, right after that edge. Results leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_sign | input | 1 | 1 for a negative operand |
| in_mag | input | 64 | Unsigned magnitude, 7 fraction bits, top bit zero |
| in_mode | input | 2 | 00 nearest-even, 01 down, 10 up, 11 toward zero |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_int | output | 32 | Rounded integer or the out-of-range marker |
| out_invalid | output | 1 | Result out of range |
| out_inexact | output | 1 | Fraction bits were nonzero |
| out_rounded_up | output | 1 | Magnitude grew during rounding |

## Verification
The properties assume that the magnitude's top bit is zero and that a producer holds `in_valid` and its operand steady until the operand is taken. The stimulus generator changes an operand only in the cycle after a handshake and clears bit 63 of every magnitude. The properties also assume that the consumer's `out_ready` may drop at any time. The bench toggles it at random to exercise the holding rule. Test magnitudes cover ties with even and odd integer parts, all-ones fractions, and the values around 2^31 for both signs.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_DOWN      = 2'b01,
    RM_UP        = 2'b10,
    RM_ZERO      = 2'b11
  } round_mode_e;
endpackage

// File: rtl/fxr_increment.sv
// Adds the mode-dependent increment below the binary point, drops the
// fraction and applies the nearest-even tie correction.
module fxr_increment #(
  parameter int MAG_W  = 64,
  parameter int FRAC_W = 7,
  localparam int IW    = MAG_W - FRAC_W
) (
  input  logic                    sign,
  input  logic [MAG_W-1:0]        mag,
  input  fxr_pkg::round_mode_e    mode,
  output logic [IW:0]             rnd_mag,
  output logic                    inexact,
  output logic                    rounded_up
);
  import fxr_pkg::*;

  localparam logic [FRAC_W-1:0] HALF = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [FRAC_W-1:0] ALL1 = {FRAC_W{1'b1}};

  logic [FRAC_W-1:0] frac;
  logic [FRAC_W-1:0] inc;
  logic [MAG_W:0]    sum;
  logic              tie;

  assign frac = mag[FRAC_W-1:0];

  always_comb begin
    case (mode)
      RM_NEAR_EVEN: inc = HALF;
      RM_DOWN:      inc = sign ? ALL1 : '0;
      RM_UP:        inc = sign ? '0 : ALL1;
      default:      inc = '0;
    endcase
  end

  assign sum        = {1'b0, mag} + {{(MAG_W+1-FRAC_W){1'b0}}, inc};
  assign tie        = (mode == RM_NEAR_EVEN) && (frac == HALF);
  assign rnd_mag    = sum[MAG_W:FRAC_W] & ~{{IW{1'b0}}, tie};
  assign inexact    = |frac;
  assign rounded_up = rnd_mag > {1'b0, mag[MAG_W-1:FRAC_W]};
endmodule

// File: rtl/fxr_range_pack.sv
// Range check, negation and marker substitution on the rounded magnitude.
module fxr_range_pack #(
  parameter int RW         = 58,
  parameter int OUT_W      = 32,
  parameter bit SIGNED_OUT = 1'b1
) (
  input  logic              sign,
  input  logic [RW-1:0]     rnd_mag,
  input  logic              inexact_raw,
  input  logic              up_raw,
  output logic [OUT_W-1:0]  value,
  output logic              invalid,
  output logic              inexact,
  output logic              rounded_up
);
  localparam int LIM_BIT = SIGNED_OUT ? OUT_W - 1 : OUT_W;
  localparam logic [RW-1:0] LIM = RW'(1) << LIM_BIT;

  logic [OUT_W-1:0] indef;
  logic [OUT_W-1:0] low;
  logic [OUT_W-1:0] signed_val;

  generate
    if (SIGNED_OUT) begin : g_signed
      assign indef = {1'b1, {(OUT_W-1){1'b0}}};
    end else begin : g_unsigned
      assign indef = {OUT_W{1'b1}};
    end
  endgenerate

  assign low        = rnd_mag[OUT_W-1:0];
  assign signed_val = sign ? (~low + 1'b1) : low;
  assign invalid    = sign ? (rnd_mag > LIM) : (rnd_mag >= LIM);
  assign value      = invalid ? indef : signed_val;
  assign inexact    = inexact_raw & ~invalid;
  assign rounded_up = up_raw & ~invalid;
endmodule

// File: rtl/fxr_stream_reg.sv
// One-entry valid/ready register stage.
module fxr_stream_reg #(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/fxr_round_conv.sv
module fxr_round_conv #(
  parameter int MAG_W      = 64,
  parameter int FRAC_W     = 7,
  parameter int OUT_W      = 32,
  parameter bit SIGNED_OUT = 1'b1,
  localparam int IW        = MAG_W - FRAC_W,
  localparam int PAY_W     = OUT_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sign,
  input  logic [MAG_W-1:0]  in_mag,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_int,
  output logic              out_invalid,
  output logic              out_inexact,
  output logic              out_rounded_up
);
  logic              sign_eff;
  logic [IW:0]       rnd_mag;
  logic              inexact_raw;
  logic              up_raw;
  logic [OUT_W-1:0]  value;
  logic              invalid;
  logic              inexact;
  logic              rounded_up;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  assign sign_eff = SIGNED_OUT ? in_sign : 1'b0;

  fxr_increment #(.MAG_W(MAG_W), .FRAC_W(FRAC_W)) inc_i (
    .sign       (sign_eff),
    .mag        (in_mag),
    .mode       (fxr_pkg::round_mode_e'(in_mode)),
    .rnd_mag    (rnd_mag),
    .inexact    (inexact_raw),
    .rounded_up (up_raw)
  );

  fxr_range_pack #(.RW(IW+1), .OUT_W(OUT_W), .SIGNED_OUT(SIGNED_OUT)) pack_i (
    .sign        (sign_eff),
    .rnd_mag     (rnd_mag),
    .inexact_raw (inexact_raw),
    .up_raw      (up_raw),
    .value       (value),
    .invalid     (invalid),
    .inexact     (inexact),
    .rounded_up  (rounded_up)
  );

  assign pay_in = {value, invalid, inexact, rounded_up};

  fxr_stream_reg #(.W(PAY_W)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_int, out_invalid, out_inexact, out_rounded_up} = pay_out;
endmodule

// File: rtl/fxr_round_conv_chk.sv
module fxr_round_conv_chk #(
  parameter int OUT_W      = 32,
  parameter bit SIGNED_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sign,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_int,
  input logic             out_invalid,
  input logic             out_inexact,
  input logic             out_rounded_up
);
  localparam logic [OUT_W-1:0] INDEF =
    SIGNED_OUT ? {1'b1, {(OUT_W-1){1'b0}}} : {OUT_W{1'b1}};

  a_r8_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_int) &&
      $stable(out_invalid) && $stable(out_inexact) && $stable(out_rounded_up)));

  a_r10_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r5_marker_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_int == INDEF && !out_inexact && !out_rounded_up));

  a_r7_up_needs_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rounded_up) |-> out_inexact);

  a_r4_positive_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (SIGNED_OUT && in_valid && in_ready && !in_sign) |=> (out_invalid || !out_int[OUT_W-1]));
endmodule

bind fxr_round_conv fxr_round_conv_chk #(.OUT_W(OUT_W), .SIGNED_OUT(SIGNED_OUT)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_sign        (in_sign),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_int        (out_int),
  .out_invalid    (out_invalid),
  .out_inexact    (out_inexact),
  .out_rounded_up (out_rounded_up)
);

// File: tb/fxr_round_conv_tb_top.sv
module fxr_round_conv_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic        in_sign;
  logic [63:0] in_mag;
  logic [1:0]  in_mode;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_int;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_rounded_up;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    bit          s;
    logic [63:0] m;
    bit [1:0]    md;
  } vec_t;

  typedef struct {
    bit [31:0] r;
    bit        inv;
    bit        ine;
    bit        up;
    bit        s;
    bit [1:0]  md;
  } exp_t;

  vec_t stim[$];
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fxr_round_conv dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_mag(in_mag), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_int(out_int),
    .out_invalid(out_invalid), .out_inexact(out_inexact),
    .out_rounded_up(out_rounded_up)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural model: decides by comparing the fraction with one half.
  function automatic exp_t model(input vec_t v);
    exp_t e;
    longint unsigned ip, rnd;
    int unsigned fr;
    ip  = longint'(v.m >> 7);
    fr  = int'(v.m[6:0]);
    rnd = ip;
    case (v.md)
      2'b00: if (fr > 64 || (fr == 64 && ip[0])) rnd = ip + 1;
      2'b01: if (v.s && fr != 0) rnd = ip + 1;
      2'b10: if (!v.s && fr != 0) rnd = ip + 1;
      default: rnd = ip;
    endcase
    e.s  = v.s;
    e.md = v.md;
    e.inv = v.s ? (rnd > 64'h8000_0000) : (rnd >= 64'h8000_0000);
    if (e.inv) begin
      e.r = 32'h8000_0000; e.ine = 0; e.up = 0;
    end else begin
      e.r   = v.s ? 32'(-rnd) : 32'(rnd);
      e.ine = (fr != 0);
      e.up  = (rnd > ip);
    end
    return e;
  endfunction

  function automatic vec_t mk(input bit s, input logic [63:0] m, input bit [1:0] md);
    vec_t v;
    v.s = s; v.m = m & 64'h7FFF_FFFF_FFFF_FFFF; v.md = md;
    return v;
  endfunction

  task automatic compare_out(input exp_t e);
    string vt;
    case (e.md)
      2'b00: vt = "R1 nearest";
      2'b11: vt = "R2 zero";
      default: vt = "R3 directed";
    endcase
    if (e.s) vt = {vt, " R4 neg"};
    check({vt, " R10 value"}, 64'(out_int), 64'(e.r));
    check("R5 invalid", 64'(out_invalid), 64'(e.inv));
    check("R6 inexact", 64'(out_inexact), 64'(e.ine));
    check("R7 rounded_up", 64'(out_rounded_up), 64'(e.up));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_int;
    logic [2:0]  held_flags;
    bit          hold_pending;
    bit          acc;
    int          idx;
    int          n_out;
    logic [63:0] b31;

    b31 = 64'h8000_0000 << 7;
    // ties with even and odd integer parts, all modes
    for (int md = 0; md < 4; md++) begin
      for (int s = 0; s < 2; s++) begin
        stim.push_back(mk(s[0], 64'h0000_0140, md[1:0]));
        stim.push_back(mk(s[0], 64'h0000_01C0, md[1:0]));
        stim.push_back(mk(s[0], 64'h0000_017F, md[1:0]));
        stim.push_back(mk(s[0], 64'h0000_0141, md[1:0]));
        stim.push_back(mk(s[0], 64'h0000_0200, md[1:0]));
        stim.push_back(mk(s[0], 64'h0, md[1:0]));
        stim.push_back(mk(s[0], 64'h0000_0040, md[1:0]));
        stim.push_back(mk(s[0], b31, md[1:0]));
        stim.push_back(mk(s[0], b31 - 1, md[1:0]));
        stim.push_back(mk(s[0], b31 - 64, md[1:0]));
        stim.push_back(mk(s[0], b31 + 1, md[1:0]));
        stim.push_back(mk(s[0], b31 - 128, md[1:0]));
        stim.push_back(mk(s[0], 64'h7FFF_FFFF_FFFF_FFFF, md[1:0]));
        stim.push_back(mk(s[0], 64'h0000_0100_0000_0000, md[1:0]));
      end
    end
    for (int k = 0; k < 300; k++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      if (k % 3 == 0) r = b31 + 64'($signed(32'($urandom % 600)) - 300);
      else r = r >> (1 + ($urandom % 60));
      stim.push_back(mk($urandom % 2, r, 2'($urandom % 4)));
    end

    rst_n = 0; in_valid = 0; in_sign = 0; in_mag = 0; in_mode = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    #1 check("R9 reset out_valid", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst_n = 1;

    idx = 0; n_out = 0; acc = 0; hold_pending = 0;
    while (n_out < stim.size()) begin
      @(negedge clk);
      if (acc) idx++;
      if (!in_valid || acc) in_valid = (idx < stim.size()) && ($urandom % 4 != 0);
      if (idx < stim.size()) begin
        in_sign = stim[idx].s; in_mag = stim[idx].m; in_mode = stim[idx].md;
      end
      out_ready = ($urandom % 3 != 0);
      #1;
      if (hold_pending) begin
        check("R8 hold value", 64'(out_int), 64'(held_int));
        check("R8 hold flags", 64'({out_invalid, out_inexact, out_rounded_up}), 64'(held_flags));
      end
      check("R8 ready rule", 64'(in_ready), 64'(!out_valid || out_ready));
      acc = in_valid && in_ready;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check("R10 unexpected output", 64'd1, 64'd0);
        else compare_out(expq.pop_front());  // R10: FIFO order
        n_out++;
      end
      hold_pending = out_valid && !out_ready;
      held_int = out_int;
      held_flags = {out_invalid, out_inexact, out_rounded_up};
      if (acc) expq.push_back(model(stim[idx]));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule